// File: doc/BRIEF.md
# Two-Stage Cascaded Clock Divider Channel

This block divides a fast input clock by passing it through two programmable counting stages in series. Both stages run in the input clock domain as clock-enable logic. The first stage counts input cycles. The second stage counts complete periods of the first stage, advancing once each time the first stage's output rises. Each stage takes its own high-run length and low-run length, each written as count-minus-one. It also takes its own phase offset, its own starting level, and a bypass control that freezes its counter and hands its input straight on to the next step.

A chip-level synchronisation request holds both stages at their starting levels and reloads their counters. After the request is released, each stage waits its phase offset and then its first run before its first edge. A channel-wide ignore-sync control makes the block deaf to that request. While ignore-sync is set, a force control pins the output high. The divided level is registered. A one-cycle tick is registered alongside it and marks each rising edge of the output.

Top module: `cdiv_cascade`

## Requirements
- R1: With the second stage bypassed and the first stage running, the output stays high for exactly `a_high`+1 input cycles per period. Field values 0 to 15 give 1 to 16 cycles.
- R2: Under the same setting, the output stays low for exactly `a_low`+1 input cycles per period.
- R3: After a sync release, a stage that starts low waits `phase`+`low`+1 of its own input ticks before its first rising edge. The registered output shows the first-stage edge `a_phase`+`a_low`+2 cycles after the first clock edge that samples `sync_req` low.
- R4: With `a_start`=1, the output is 1 while sync is held. The first falling edge after release appears `a_phase`+`a_high`+2 cycles after release.
- R5: With neither stage bypassed, the output is high for (`b_high`+1)×(`a_high`+`a_low`+2) cycles and low for (`b_low`+1)×(`a_high`+`a_low`+2) cycles. `div_tick` is 1 only in the first cycle of each high run.
- R6: A set bypass bit freezes that stage and routes its input to its output. With only the first stage bypassed, the second stage counts every input cycle. With both bypassed, `div_lvl`=1 and `div_tick`=1 every cycle.
- R7: With `ign_sync`=1, a raised `sync_req` has no effect and the output keeps toggling.
- R8: `ign_sync`=1 together with `force_hi`=1 drives `div_lvl`=1 and `div_tick`=0. `force_hi` alone, with `ign_sync`=0, changes nothing.
- R9: A change to a high or low count takes effect only at the next boundary between runs. The run in progress keeps its old length.
- R10: While `sync_req`=1 is obeyed, each stage holds its start level and the output does not change.
- R11: Synchronous reset clears `div_lvl` and `div_tick` to 0 and treats both stages as held in sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req | input | 1 | Chip-level sync request, active high |
| a_high | input | CW | First stage high run, cycles minus one |
| a_low | input | CW | First stage low run, cycles minus one |
| a_phase | input | CW | First stage offset applied after sync |
| a_start | input | 1 | First stage start level |
| a_bypass | input | 1 | First stage bypass |
| b_high | input | CW | Second stage high run, first-stage periods minus one |
| b_low | input | CW | Second stage low run, first-stage periods minus one |
| b_phase | input | CW | Second stage offset after sync |
| b_start | input | 1 | Second stage start level |
| b_bypass | input | 1 | Second stage bypass |
| ign_sync | input | 1 | Ignore the sync request |
| force_hi | input | 1 | Force output high while ign_sync is set |
| div_lvl | output | 1 | Divided output level, registered |
| div_tick | output | 1 | One-cycle marker of each output rise |

## Verification
The bench targets the sync-release delay with and without a phase offset. A design that starts the phase count one tick late, or skips it, shifts the first edge. It also targets the extreme run lengths of 1 and 16 cycles, where an off-by-one in the count-minus-one decode gives 2 or 15 cycles. A count rewritten in the middle of a high run must not shorten or stretch that run; a design that reloaded at once would emit a runt. The remaining checks cover the cascade product, each bypass path, and the ignore-sync and force interplay. A design that let the force act without ignore-sync would freeze a normally running channel.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
  typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} lvl_e;
  localparam int NSTG = 2;
endpackage

// File: rtl/cdiv_stage.sv
`timescale 1ns/1ps
module cdiv_stage #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          hold,
  input  logic          tick_in,
  input  logic [CW-1:0] cfg_high,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_phase,
  input  logic          cfg_start,
  output logic          lvl,
  output logic          rise
);
  import cdiv_pkg::*;
  localparam int SW = CW + 1;

  logic [SW-1:0] cnt_q;
  lvl_e          lvl_q;
  logic          at_end;

  assign at_end = (cnt_q == '0);
  assign rise   = tick_in & at_end & (lvl_q == LVL_LOW) & ~hold;
  assign lvl    = (lvl_q == LVL_HIGH);

  // Counter reloads from the live fields only at a run boundary.
  always_ff @(posedge clk) begin
    if (hold) begin
      lvl_q <= cfg_start ? LVL_HIGH : LVL_LOW;
      cnt_q <= SW'(cfg_phase) + SW'(cfg_start ? cfg_high : cfg_low);
    end else if (tick_in) begin
      if (at_end) begin
        lvl_q <= (lvl_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
        cnt_q <= SW'((lvl_q == LVL_HIGH) ? cfg_low : cfg_high);
      end else begin
        cnt_q <= cnt_q - SW'(1);
      end
    end
  end
endmodule

// File: rtl/cdiv_outsel.sv
`timescale 1ns/1ps
module cdiv_outsel (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  input  logic tick_in,
  input  logic all_byp,
  input  logic forced,
  output logic div_lvl,
  output logic div_tick
);
  logic lvl_nxt;
  logic tick_nxt;

  assign lvl_nxt  = forced | lvl_in;
  assign tick_nxt = ~forced & (all_byp ? tick_in : (lvl_nxt & ~div_lvl));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_lvl  <= 1'b0;
      div_tick <= 1'b0;
    end else begin
      div_lvl  <= lvl_nxt;
      div_tick <= tick_nxt;
    end
  end
endmodule

// File: rtl/cdiv_cascade.sv
`timescale 1ns/1ps
module cdiv_cascade #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_req,
  input  logic [CW-1:0] a_high,
  input  logic [CW-1:0] a_low,
  input  logic [CW-1:0] a_phase,
  input  logic          a_start,
  input  logic          a_bypass,
  input  logic [CW-1:0] b_high,
  input  logic [CW-1:0] b_low,
  input  logic [CW-1:0] b_phase,
  input  logic          b_start,
  input  logic          b_bypass,
  input  logic          ign_sync,
  input  logic          force_hi,
  output logic          div_lvl,
  output logic          div_tick
);
  import cdiv_pkg::*;

  logic [CW-1:0] c_high  [NSTG];
  logic [CW-1:0] c_low   [NSTG];
  logic [CW-1:0] c_phase [NSTG];
  logic [NSTG-1:0] c_start, c_byp, stg_lvl, stg_rise;
  logic [NSTG:0]   chain_lvl, chain_tick;
  logic hold;

  assign c_high[0]  = a_high;  assign c_high[1]  = b_high;
  assign c_low[0]   = a_low;   assign c_low[1]   = b_low;
  assign c_phase[0] = a_phase; assign c_phase[1] = b_phase;
  assign c_start    = {b_start, a_start};
  assign c_byp      = {b_bypass, a_bypass};

  assign hold          = rst | (sync_req & ~ign_sync);
  assign chain_lvl[0]  = 1'b1;
  assign chain_tick[0] = 1'b1;

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    logic tick_g;
    assign tick_g = chain_tick[g] & ~c_byp[g];
    cdiv_stage #(.CW(CW)) u_stage (
      .clk       (clk),
      .hold      (hold),
      .tick_in   (tick_g),
      .cfg_high  (c_high[g]),
      .cfg_low   (c_low[g]),
      .cfg_phase (c_phase[g]),
      .cfg_start (c_start[g]),
      .lvl       (stg_lvl[g]),
      .rise      (stg_rise[g])
    );
    assign chain_lvl[g+1]  = c_byp[g] ? chain_lvl[g]  : stg_lvl[g];
    assign chain_tick[g+1] = c_byp[g] ? chain_tick[g] : stg_rise[g];
  end

  cdiv_outsel u_out (
    .clk      (clk),
    .rst      (rst),
    .lvl_in   (chain_lvl[NSTG]),
    .tick_in  (chain_tick[NSTG]),
    .all_byp  (&c_byp),
    .forced   (ign_sync & force_hi),
    .div_lvl  (div_lvl),
    .div_tick (div_tick)
  );
endmodule

// File: rtl/cdiv_cascade_chk.sv
`timescale 1ns/1ps
module cdiv_cascade_chk (
  input logic clk,
  input logic rst,
  input logic hold,
  input logic ign_sync,
  input logic force_hi,
  input logic a_bypass,
  input logic b_bypass,
  input logic a_start,
  input logic b_start,
  input logic s1_lvl,
  input logic s2_lvl,
  input logic div_lvl,
  input logic div_tick
);
  a_r10_hold_start_a: assert property (@(posedge clk) disable iff (rst)
    (hold && !rst) |=> (s1_lvl == $past(a_start)));
  a_r10_hold_start_b: assert property (@(posedge clk) disable iff (rst)
    (hold && !rst) |=> (s2_lvl == $past(b_start)));
  a_r8_force_high: assert property (@(posedge clk) disable iff (rst)
    (ign_sync && force_hi && !rst) |=> (div_lvl && !div_tick));
  a_r6_full_bypass: assert property (@(posedge clk) disable iff (rst)
    (a_bypass && b_bypass && !(ign_sync && force_hi) && !rst) |=> (div_lvl && div_tick));
  a_r5_tick_when_high: assert property (@(posedge clk) disable iff (rst)
    div_tick |-> div_lvl);
endmodule

bind cdiv_cascade cdiv_cascade_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .hold     (hold),
  .ign_sync (ign_sync),
  .force_hi (force_hi),
  .a_bypass (a_bypass),
  .b_bypass (b_bypass),
  .a_start  (a_start),
  .b_start  (b_start),
  .s1_lvl   (stg_lvl[0]),
  .s2_lvl   (stg_lvl[1]),
  .div_lvl  (div_lvl),
  .div_tick (div_tick)
);

// File: tb/cdiv_cascade_tb.sv
`timescale 1ns/1ps
module cdiv_cascade_tb;
  logic clk = 1'b0;
  logic rst = 1'b1, sync_req = 1'b0;
  logic [3:0] a_high = 0, a_low = 0, a_phase = 0, b_high = 0, b_low = 0, b_phase = 0;
  logic a_start = 0, a_bypass = 0, b_start = 0, b_bypass = 0, ign_sync = 0, force_hi = 0;
  logic div_lvl, div_tick;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R11";

  int m_lvl [2];
  int m_rem [2];
  bit m_out = 0, m_tick = 0;

  always #2.5 clk = ~clk;

  cdiv_cascade u_dut (.*);

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic upd(int i, bit tk, bit hld, bit st, int ph, int hi, int lo);
    if (hld) begin
      m_lvl[i] = st;
      m_rem[i] = ph + (st ? hi : lo) + 1;
    end else if (tk) begin
      if (m_rem[i] == 1) begin
        m_lvl[i] = (m_lvl[i] == 0) ? 1 : 0;
        m_rem[i] = (m_lvl[i] != 0 ? hi : lo) + 1;
      end else m_rem[i]--;
    end
  endtask

  task automatic step_model();
    bit hld, l1, lf, forced, nout, ntick, rise1, t2;
    hld    = rst || (sync_req && !ign_sync);
    forced = ign_sync && force_hi;
    l1 = a_bypass ? 1'b1 : (m_lvl[0] != 0);
    lf = b_bypass ? l1 : (m_lvl[1] != 0);
    if (rst) begin nout = 0; ntick = 0; end
    else begin
      nout  = forced ? 1'b1 : lf;
      ntick = !forced && ((a_bypass && b_bypass) || (nout && !m_out));
    end
    rise1 = !hld && !a_bypass && m_rem[0] == 1 && m_lvl[0] == 0;
    t2    = !b_bypass && (a_bypass || rise1);
    upd(0, !a_bypass, hld, a_start, a_phase, a_high, a_low);
    upd(1, t2, hld, b_start, b_phase, b_high, b_low);
    m_out = nout; m_tick = ntick;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    step_model();
    check(div_lvl == m_out, {cur_req, " level vs model"}, div_lvl, m_out);
    check(div_tick == m_tick, {cur_req, " tick vs model"}, div_tick, m_tick);
  endtask

  task automatic do_sync();
    sync_req = 1; repeat (3) cyc(); sync_req = 0;
  endtask

  task automatic delay_to(bit v, output int n);
    n = 0;
    do begin cyc(); n++; end while (div_lvl != v && n < 2000);
  endtask

  task automatic run_len(output int n);
    bit v = div_lvl;
    n = 1;
    forever begin cyc(); if (div_lvl == v && n < 2000) n++; else break; end
  endtask

  task automatic to_rise();
    int n;
    if (div_lvl) delay_to(0, n);
    delay_to(1, n);
  endtask

  initial begin
    int n, hl, ll, chg;
    repeat (4) cyc();
    check(div_lvl == 0 && div_tick == 0, "R11 reset outputs", div_lvl, 0);
    rst = 0;

    // R1 R2 R3 stage A only
    cur_req = "R1"; b_bypass = 1; a_high = 2; a_low = 1;
    do_sync(); delay_to(1, n); check(n == 3, "R3 release delay", n, 3);
    run_len(hl); check(hl == 3, "R1 high run", hl, 3);
    run_len(ll); check(ll == 2, "R2 low run", ll, 2);
    cur_req = "R3"; a_phase = 5;
    do_sync(); delay_to(1, n); check(n == 8, "R3 offset delay", n, 8);
    cur_req = "R1"; a_phase = 0; a_high = 15; a_low = 15; do_sync();
    to_rise(); run_len(hl); check(hl == 16, "R1 max high", hl, 16);
    run_len(ll); check(ll == 16, "R2 max low", ll, 16);
    a_high = 0; a_low = 0; do_sync(); to_rise();
    run_len(hl); check(hl == 1, "R1 min high", hl, 1);
    run_len(ll); check(ll == 1, "R2 min low", ll, 1);

    // R4 start high
    cur_req = "R4"; a_start = 1; a_phase = 2; a_high = 2; a_low = 1;
    sync_req = 1; repeat (3) cyc();
    check(div_lvl == 1, "R4 held at start high", div_lvl, 1);
    sync_req = 0; delay_to(0, n); check(n == 6, "R4 delay to fall", n, 6);
    a_start = 0; a_phase = 0;

    // R5 cascade
    cur_req = "R5"; b_bypass = 0; a_high = 1; a_low = 0; b_high = 1; b_low = 2;
    do_sync(); delay_to(1, n); check(n == 8, "R5 cascade delay", n, 8);
    check(div_tick == 1, "R5 tick on rise", div_tick, 1);
    run_len(hl); check(hl == 6, "R5 cascade high", hl, 6);
    run_len(ll); check(ll == 9, "R5 cascade low", ll, 9);

    // R6 bypass
    cur_req = "R6"; a_bypass = 1; b_high = 3; b_low = 1;
    do_sync(); delay_to(1, n); check(n == 3, "R6 bypass A delay", n, 3);
    run_len(hl); check(hl == 4, "R6 bypass A high", hl, 4);
    run_len(ll); check(ll == 2, "R6 bypass A low", ll, 2);
    b_bypass = 1; cyc(); cyc();
    check(div_lvl == 1 && div_tick == 1, "R6 full bypass", div_tick, 1);
    a_bypass = 0;

    // R7 ignore sync
    cur_req = "R7"; a_high = 1; a_low = 1; do_sync(); to_rise();
    ign_sync = 1; sync_req = 1; chg = 0;
    for (int i = 0; i < 12; i++) begin bit p = div_lvl; cyc(); if (div_lvl != p) chg++; end
    check(chg >= 5, "R7 keeps toggling", chg, 6);

    // R8 force
    cur_req = "R8"; sync_req = 0; force_hi = 1; cyc();
    for (int i = 0; i < 6; i++) begin
      cyc(); check(div_lvl == 1 && div_tick == 0, "R8 forced high", div_lvl, 1);
    end
    ign_sync = 0; cyc(); to_rise(); run_len(hl);
    check(hl == 2, "R8 force ignored without ign_sync", hl, 2);
    force_hi = 0;

    // R10 sync hold
    cur_req = "R10"; sync_req = 1; cyc(); cyc(); chg = 0;
    for (int i = 0; i < 10; i++) begin bit p = div_lvl; cyc(); if (div_lvl != p) chg++; end
    check(chg == 0, "R10 static during sync", chg, 0);
    sync_req = 0;

    // R9 mid-run change
    cur_req = "R9"; a_high = 3; a_low = 3; do_sync(); to_rise();
    a_high = 7; hl = 1;
    forever begin cyc(); if (div_lvl == 1 && hl < 2000) hl++; else break; end
    check(hl == 4, "R9 current run keeps old length", hl, 4);
    run_len(ll); check(ll == 4, "R9 low run", ll, 4);
    run_len(hl); check(hl == 8, "R9 next run uses new length", hl, 8);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5ns * 50000);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule